// File: doc/BRIEF.md
# Jittered Sampling Interval Counter

This block decides when a statistical profiling unit takes its next operation sample. Software programs a 64-bit control word that holds a coarse interval and a jitter enable. The interval counts in steps of 256 events. A down-counter loads the interval and decrements on every countable event. When the counter expires, the block raises a one-cycle sample pulse and reloads the counter in the same cycle.

When jitter is enabled, each reload gets a pseudo-random value from 0 to 255 added to it. The value comes from a 16-bit maximal-length LFSR. A programmed interval below the hardware minimum, including zero, is raised to the parameter `MIN_INTERVAL` (default 512). A register write never disturbs the count in progress. It is picked up only at the next reload.

Top module: `sample_interval_timer`

## Requirements
- R1: After reset the register reads as zero, `sample_o` is low, the counter holds `MIN_INTERVAL`, and the first sample fires on the `MIN_INTERVAL`-th counted event.
- R2: The read value is `{32'b0, interval[23:0], 7'b0, rnd}`. Interval sits at bits 31:8 and the jitter enable at bit 0. Writes to bits 63:32 and 7:1 are dropped, and those bits read as zero.
- R3: The counter decrements only in a cycle where both `enable_i` and `event_i` are high. In any other cycle the count holds and no sample fires.
- R4: When a counted event takes the count to zero, `sample_o` is high for exactly the next cycle. At that same clock edge the counter reloads.
- R5: With rnd=0 the reload equals the interval field shifted left by 8, so bits 7:0 are zero.
- R6: A reload base below `MIN_INTERVAL`, zero included, is replaced by `MIN_INTERVAL`.
- R7: With rnd=1 the reload equals the base from R5/R6 plus the low 8 bits of the LFSR state present at the reload edge. The LFSR shifts left with a new bit0 = s[15]^s[13]^s[12]^s[10], and its seed is 16'hACE1.
- R8: A register write changes no count in progress. A reload that happens at the same edge as a write still uses the old value.
- R9: The LFSR advances once per reload, whatever rnd is, and holds otherwise. It is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Counting enable |
| event_i | input | 1 | Countable event strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data |
| sample_o | output | 1 | One-cycle sample request |

## Verification
A register write and a counter expiry can land on the same clock edge. The bench provokes this by counting ticks from a known sample and issuing the write together with the final tick. It then checks that the pulse still fires and that the next period has the old length. Only the period after that may have the new length. The same pulse is also checked to drop after one cycle while counting continues.

// File: rtl/sitimer_pkg.sv
package sitimer_pkg;
  localparam int REG_W   = 64;
  localparam int IVL_LSB = 8;
  localparam int IVL_W   = 24;
  localparam int CNT_W   = IVL_LSB + IVL_W;

  typedef struct packed {
    logic [IVL_W-1:0] ivl;
    logic             rnd;
  } cfg_t;
endpackage

// File: rtl/sit_cfg_reg.sv
module sit_cfg_reg
  import sitimer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[REG_W-1:CNT_W], wdata_i[IVL_LSB-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (we_i) begin
      cfg_q.ivl <= wdata_i[CNT_W-1:IVL_LSB];
      cfg_q.rnd <= wdata_i[0];
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(REG_W-CNT_W){1'b0}}, cfg_q.ivl, {(IVL_LSB-1){1'b0}}, cfg_q.rnd};

  a_r2_write_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[CNT_W-1:IVL_LSB] == $past(wdata_i[CNT_W-1:IVL_LSB]))
             && (rdata_o[0] == $past(wdata_i[0])));
endmodule

// File: rtl/sit_jitter_lfsr.sv
module sit_jitter_lfsr #(
  parameter int              LFSR_W = 16,
  parameter int              JIT_W  = 8,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [JIT_W-1:0] jitter_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign jitter_o = state_q[JIT_W-1:0];

  a_r9_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni) state_q != '0);
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
endmodule

// File: rtl/sit_reload_calc.sv
module sit_reload_calc
  import sitimer_pkg::*;
#(
  parameter int unsigned MIN_INTERVAL = 512,
  parameter int          JIT_W        = 8
) (
  input  cfg_t             cfg_i,
  input  logic [JIT_W-1:0] jitter_i,
  output logic [CNT_W-1:0] reload_o
);
  logic [CNT_W-1:0] base, floor_v;

  always_comb begin
    base    = {cfg_i.ivl, {IVL_LSB{1'b0}}};
    floor_v = (base < CNT_W'(MIN_INTERVAL)) ? CNT_W'(MIN_INTERVAL) : base;
    reload_o = floor_v + (cfg_i.rnd ? CNT_W'(jitter_i) : '0);
  end
endmodule

// File: rtl/sit_down_counter.sv
module sit_down_counter #(
  parameter int          CNT_W        = 32,
  parameter int unsigned MIN_INTERVAL = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o,
  output logic             sample_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sample_q;

  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_W'(MIN_INTERVAL);
      sample_q <= 1'b0;
    end else begin
      sample_q <= expire_o;
      if (expire_o)    cnt_q <= reload_i;
      else if (tick_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign sample_o = sample_q;

  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  a_r4_reload_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == $past(reload_i));
  a_r6_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> reload_i >= CNT_W'(MIN_INTERVAL));
  a_r4_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q != '0);
endmodule

// File: rtl/sample_interval_timer.sv
module sample_interval_timer
  import sitimer_pkg::*;
#(
  parameter int unsigned MIN_INTERVAL = 512,
  parameter int          LFSR_W       = 16,
  parameter int          JIT_W        = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             event_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             sample_o
);
  cfg_t             cfg;
  logic [JIT_W-1:0] jitter;
  logic [CNT_W-1:0] reload;
  logic             tick, expire;

  assign tick = enable_i & event_i;

  sit_cfg_reg u_cfg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .cfg_o(cfg)
  );

  sit_jitter_lfsr #(.LFSR_W(LFSR_W), .JIT_W(JIT_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i, .rst_ni, .step_i(expire), .jitter_o(jitter)
  );

  sit_reload_calc #(.MIN_INTERVAL(MIN_INTERVAL), .JIT_W(JIT_W)) u_calc (
    .cfg_i(cfg), .jitter_i(jitter), .reload_o(reload)
  );

  sit_down_counter #(.CNT_W(CNT_W), .MIN_INTERVAL(MIN_INTERVAL)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .reload_i(reload),
    .expire_o(expire), .sample_o
  );

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:CNT_W] == '0 && reg_rdata_o[IVL_LSB-1:1] == '0);
  a_r3_no_sample_unless_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> !sample_o);
endmodule

// File: tb/sim_sample_interval_timer.sv
module sim_sample_interval_timer;
  localparam int MIN_IVL = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, evt = 1'b0, we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        sample;

  int total = 0, bad = 0;
  logic [15:0] lfsr_m = 16'hACE1;

  always #5ns clk = ~clk;

  sample_interval_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .event_i(evt),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sample_o(sample)
  );

  function automatic logic [15:0] lfsr_step(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [63:0] v);
    @(negedge clk); en = 0; evt = 0; we = 1; wdata = v;
    @(negedge clk); we = 0;
  endtask

  // counts ticks until sample; jit = model state low byte at that reload
  task automatic wait_sample(input bit gaps, output int n, output logic [7:0] jit);
    int cyc = 0;
    n = 0; jit = '0;
    forever begin
      @(negedge clk);
      en = 1; evt = gaps ? (cyc % 3 != 2) : 1'b1;
      cyc++;
      @(posedge clk); #1;
      if (evt) n++;
      if (sample) begin
        jit = lfsr_m[7:0];
        lfsr_m = lfsr_step(lfsr_m);
        break;
      end
      if (cyc > 20000) begin n = -1; break; end
    end
  endtask

  task automatic tick_n(int k, output int seen);
    seen = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk); en = 1; evt = 1;
      @(posedge clk); #1;
      if (sample) seen++;
    end
  endtask

  // wdata, base period (before jitter), gaps in event stream
  typedef struct packed { logic [63:0] w; logic [31:0] base; logic gaps; } vec_t;
  localparam vec_t VECS [7] = '{
    '{64'h0000_0000_0000_0300, 32'd768,  1'b0},  // R5
    '{64'hFFFF_FFFF_0000_02FE, 32'd512,  1'b0},  // R2 reserved dropped, R5
    '{64'h0000_0000_0000_0000, 32'd512,  1'b0},  // R6 zero
    '{64'h0000_0000_0000_0100, 32'd512,  1'b1},  // R6 below min
    '{64'h0000_0000_0000_0101, 32'd512,  1'b0},  // R6 + R7
    '{64'h0000_0000_0000_0401, 32'd1024, 1'b1},  // R7
    '{64'h0000_0000_0000_0500, 32'd1280, 1'b1}   // R3 gaps, R5
  };

  initial begin
    #1_900_000ns;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, seen;
    logic [7:0] j0, j1;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    check("R1 rdata", rdata, 0);
    check("R1 sample", sample, 0);
    wait_sample(0, n, j0);
    check("R1 first period", n, MIN_IVL);

    foreach (VECS[i]) begin
      reg_write(VECS[i].w);
      check("R2 readback", rdata, VECS[i].w & 64'h0000_0000_FFFF_FF01);
      wait_sample(VECS[i].gaps, n, j0);   // period in flight uses old value (R8)
      wait_sample(VECS[i].gaps, n, j1);
      check(VECS[i].w[0] ? "R7 jitter period" : "R5/R6 period", n,
            VECS[i].base + (VECS[i].w[0] ? j0 : 8'd0));
    end

    // R8 + R4: write lands on the expiry edge
    reg_write(64'h300);
    wait_sample(0, n, j0);
    tick_n(767, seen);
    check("R4 no early sample", seen, 0);
    @(negedge clk); en = 1; evt = 1; we = 1; wdata = 64'h600;
    @(posedge clk); #1;
    check("R8 pulse on write edge", sample, 1);
    lfsr_m = lfsr_step(lfsr_m);
    @(negedge clk); we = 0;
    @(posedge clk); #1;
    check("R4 one-cycle pulse", sample, 0);
    wait_sample(0, n, j0);
    check("R8 old value kept", n, 767);
    wait_sample(0, n, j0);
    check("R8 new value next", n, 1536);

    // R3: idle cycles do not count
    tick_n(100, seen);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); en = (i >= 200); evt = (i < 200);
      @(posedge clk); #1;
      if (sample) seen++;
    end
    check("R3 no sample while idle", seen, 0);
    wait_sample(0, n, j0);
    check("R3 remaining count", n, 1436);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule